// File: doc/BRIEF.md
# Four-Channel Parameter Frame Receiver

This block sits between a host byte link and four signal generators. The host presents a byte on an 8-bit data bus and raises a strobe that is not related to the block's clock. The block resynchronises that strobe, takes one byte for each rising edge, and builds a 16-byte frame. The frame holds one 32-bit parameter word for each of four channels. Each word splits into a satellite number, an amplitude, a two-bit rollover flag field and a phase value. Frames nominally arrive at 2 kHz, which is 32 kB/s, far below what the capture path can take.

Decoded words first land in a shadow bank. Only the sixteenth byte of a frame moves all four channels into the active bank, and it does so in a single cycle. The same event raises a one-cycle `params_valid` pulse. The generators therefore never see a mix of old and new channels.

Two things put the byte counter back to the start of a frame: a `frame_start` pulse, or an idle gap in the middle of a frame that reaches a programmable limit. A frame cut short this way never reaches the active bank, and it sets a sticky error bit that the host clears.

Top module: `chan_frame_rx`

## Requirements
- R1: Each rising edge of `host_strobe` is passed through a two-flop synchroniser and captures `host_data` exactly once, however long the strobe stays high.
- R2: A frame is 16 captured bytes. Bytes 0-3 form channel 0, bytes 4-7 form channel 1, and so on up to channel 3. Within a channel the first byte is the most significant byte of the word.
- R3: In each 32-bit word, bits [31:27] are the satellite number, [26:20] the amplitude, [19:18] the rollover flags and [17:0] the phase. Channel k appears at `sat_num[5k+4:5k]`, `amplitude[7k+6:7k]`, `roll_flags[2k+1:2k]` and `phase[18k+17:18k]`.
- R4: The active outputs of all four channels change together, and only after the sixteenth byte of a frame. At every other time they hold their value, including while a frame is partly received.
- R5: `params_valid` is high for exactly one cycle per completed frame, in the cycle where the new active values first appear.
- R6: A high `frame_start` returns the byte counter to channel 0, byte 0. A byte captured in the same cycle is dropped. A `frame_start` that arrives while the counter is already at byte 0 sets no error.
- R7: In the middle of a frame, `idle_limit` consecutive cycles without a captured byte cause the same resync as `frame_start`. An `idle_limit` of 0 turns the timeout off.
- R8: A resync in the middle of a frame throws away that frame's partial contents, so the active outputs keep their values. It also sets `frame_error`.
- R9: `frame_error` stays set until `err_clear` is high. If a new error arrives in the same cycle as `err_clear`, the error wins.
- R10: After reset, all active outputs, `params_valid` and `frame_error` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_data | input | 8 | Byte from the host, stable while the strobe is high |
| host_strobe | input | 1 | Asynchronous byte strobe; a rising edge marks a new byte |
| frame_start | input | 1 | Synchronous resync request |
| err_clear | input | 1 | Clears the sticky error |
| idle_limit | input | 16 | Idle-cycle timeout within a frame; 0 turns it off |
| sat_num | output | 20 | Active satellite numbers, 5 bits per channel |
| amplitude | output | 28 | Active amplitudes, 7 bits per channel |
| roll_flags | output | 8 | Active rollover flags, 2 bits per channel |
| phase | output | 72 | Active phases, 18 bits per channel |
| params_valid | output | 1 | One-cycle pulse when a new frame is committed |
| frame_error | output | 1 | Sticky flag for a discarded partial frame |

## Verification
A byte counter that is off by one shows up within one frame as fields that have rotated between channels or bytes. Well-separated test values expose it at the first commit. A lost resync shows up at the next frame as misaligned words and a missing `frame_error`. A commit at the wrong time shows up as active outputs that move in the middle of a frame, or as a `params_valid` pulse without a frame, in the cycle it happens. A strobe edge counted twice shifts every field after it and is visible at the next commit.

// File: rtl/chan_frame_pkg.sv
package chan_frame_pkg;
  localparam int SAT_W  = 5;
  localparam int AMP_W  = 7;
  localparam int FLG_W  = 2;
  localparam int PH_W   = 18;
  localparam int WORD_W = SAT_W + AMP_W + FLG_W + PH_W;
  localparam int BYTE_W = 8;
  localparam int BYTES_PER_CH = WORD_W / BYTE_W;

  typedef struct packed {
    logic [SAT_W-1:0] sat;
    logic [AMP_W-1:0] amp;
    logic [FLG_W-1:0] flg;
    logic [PH_W-1:0]  ph;
  } chan_word_t;
endpackage

// File: rtl/cfr_strobe_sync.sv
module cfr_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_in,
  output logic rise
);
  logic [STAGES:0] sh_q;
  logic [STAGES:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-1:0], strobe_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/cfr_frame_assembler.sv
module cfr_frame_assembler
  import chan_frame_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int IDLE_W = 16,
  localparam int FRAME_BYTES = NUM_CH * BYTES_PER_CH,
  localparam int IDX_W  = $clog2(FRAME_BYTES),
  localparam int BSEL_W = $clog2(BYTES_PER_CH),
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int ACC_W  = BYTE_W * (BYTES_PER_CH - 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_rise,
  input  logic [BYTE_W-1:0] byte_in,
  input  logic              frame_start,
  input  logic              err_clear,
  input  logic [IDLE_W-1:0] idle_limit,
  output logic              wr_en,
  output logic [CH_W-1:0]   wr_ch,
  output logic [WORD_W-1:0] wr_word,
  output logic              commit,
  output logic              frame_error,
  output logic [IDX_W-1:0]  byte_idx,
  output logic              resync
);
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [IDLE_W-1:0] idle_q, idle_d;
  logic [ACC_W-1:0]  acc_q, acc_d;
  logic              commit_q, commit_d;
  logic              err_q, err_d;
  logic              timeout, take, last, mid_frame;

  always_comb begin
    mid_frame = (idx_q != '0);
    last      = (idx_q == IDX_W'(FRAME_BYTES - 1));
    timeout   = (idle_limit != '0) && mid_frame && (idle_q >= idle_limit);
    resync    = frame_start | timeout;
    take      = byte_rise & ~resync;

    if (resync)     idx_d = '0;
    else if (take)  idx_d = last ? '0 : idx_q + 1'b1;
    else            idx_d = idx_q;

    if (resync || take || !mid_frame) idle_d = '0;
    else if (idle_q != '1)            idle_d = idle_q + 1'b1;
    else                              idle_d = idle_q;

    acc_d = take ? {acc_q[ACC_W-BYTE_W-1:0], byte_in} : acc_q;

    wr_en   = take && (idx_q[BSEL_W-1:0] == BSEL_W'(BYTES_PER_CH - 1));
    wr_ch   = CH_W'(idx_q >> BSEL_W);
    wr_word = {acc_q, byte_in};

    commit_d = take && last;

    if (resync && mid_frame) err_d = 1'b1;
    else if (err_clear)      err_d = 1'b0;
    else                     err_d = err_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q    <= '0;
      idle_q   <= '0;
      acc_q    <= '0;
      commit_q <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      idx_q    <= idx_d;
      idle_q   <= idle_d;
      acc_q    <= acc_d;
      commit_q <= commit_d;
      err_q    <= err_d;
    end
  end

  assign commit      = commit_q;
  assign frame_error = err_q;
  assign byte_idx    = idx_q;
endmodule

// File: rtl/cfr_param_bank.sv
module cfr_param_bank
  import chan_frame_pkg::*;
#(
  parameter int NUM_CH = 4,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [CH_W-1:0]          wr_ch,
  input  logic [WORD_W-1:0]        wr_word,
  input  logic                     commit,
  output logic [NUM_CH*WORD_W-1:0] active_flat,
  output logic                     valid
);
  logic valid_q;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic [WORD_W-1:0] shadow_q, shadow_d;
    logic [WORD_W-1:0] active_q, active_d;

    always_comb begin
      shadow_d = (wr_en && (wr_ch == CH_W'(g))) ? wr_word : shadow_q;
      active_d = commit ? shadow_q : active_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        shadow_q <= '0;
        active_q <= '0;
      end else begin
        shadow_q <= shadow_d;
        active_q <= active_d;
      end
    end

    assign active_flat[g*WORD_W +: WORD_W] = active_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= commit;
  end

  assign valid = valid_q;
endmodule

// File: rtl/chan_frame_rx.sv
module chan_frame_rx
  import chan_frame_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int IDLE_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [BYTE_W-1:0]       host_data,
  input  logic                    host_strobe,
  input  logic                    frame_start,
  input  logic                    err_clear,
  input  logic [IDLE_W-1:0]       idle_limit,
  output logic [NUM_CH*SAT_W-1:0] sat_num,
  output logic [NUM_CH*AMP_W-1:0] amplitude,
  output logic [NUM_CH*FLG_W-1:0] roll_flags,
  output logic [NUM_CH*PH_W-1:0]  phase,
  output logic                    params_valid,
  output logic                    frame_error
);
  localparam int FRAME_BYTES = NUM_CH * BYTES_PER_CH;
  localparam int IDX_W = $clog2(FRAME_BYTES);
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic                     byte_rise;
  logic                     wr_en;
  logic [CH_W-1:0]          wr_ch;
  logic [WORD_W-1:0]        wr_word;
  logic                     commit;
  logic [IDX_W-1:0]         byte_idx;
  logic                     resync;
  logic [NUM_CH*WORD_W-1:0] active_flat;

  cfr_strobe_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .strobe_in(host_strobe), .rise(byte_rise)
  );

  cfr_frame_assembler #(.NUM_CH(NUM_CH), .IDLE_W(IDLE_W)) u_asm (
    .clk(clk), .rst_n(rst_n), .byte_rise(byte_rise), .byte_in(host_data),
    .frame_start(frame_start), .err_clear(err_clear), .idle_limit(idle_limit),
    .wr_en(wr_en), .wr_ch(wr_ch), .wr_word(wr_word), .commit(commit),
    .frame_error(frame_error), .byte_idx(byte_idx), .resync(resync)
  );

  cfr_param_bank #(.NUM_CH(NUM_CH)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ch(wr_ch), .wr_word(wr_word),
    .commit(commit), .active_flat(active_flat), .valid(params_valid)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_unpack
    chan_word_t w;
    assign w = chan_word_t'(active_flat[g*WORD_W +: WORD_W]);
    assign sat_num[g*SAT_W +: SAT_W]    = w.sat;
    assign amplitude[g*AMP_W +: AMP_W]  = w.amp;
    assign roll_flags[g*FLG_W +: FLG_W] = w.flg;
    assign phase[g*PH_W +: PH_W]        = w.ph;
  end
endmodule

// File: rtl/chan_frame_rx_chk.sv
module chan_frame_rx_chk #(
  parameter int NUM_CH = 4,
  parameter int IDX_W  = 4,
  parameter int WORD_W = 32
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     err_clear,
  input logic                     params_valid,
  input logic                     frame_error,
  input logic                     byte_rise,
  input logic                     resync,
  input logic [IDX_W-1:0]         byte_idx,
  input logic [NUM_CH*WORD_W-1:0] active_flat
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_CH * 4 - 1);

  p_rise_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
    byte_rise |=> !byte_rise);

  p_idx_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_rise && !resync && byte_idx != LAST_IDX) |=> byte_idx == $past(byte_idx) + 1'b1);

  p_active_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !params_valid |-> $stable(active_flat));

  p_commit_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
    params_valid |-> ($past(byte_rise, 2) && $past(byte_idx, 2) == LAST_IDX));

  p_valid_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    params_valid |=> !params_valid);

  p_resync_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    resync |=> byte_idx == '0);

  p_err_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (resync && byte_idx != '0) |=> frame_error);

  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_error && !err_clear) |=> frame_error);
endmodule

bind chan_frame_rx chan_frame_rx_chk #(.NUM_CH(NUM_CH), .IDX_W(IDX_W), .WORD_W(chan_frame_pkg::WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .err_clear(err_clear), .params_valid(params_valid),
  .frame_error(frame_error), .byte_rise(byte_rise), .resync(resync),
  .byte_idx(byte_idx), .active_flat(active_flat)
);

// File: tb/chan_frame_rx_bench.sv
module chan_frame_rx_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  host_data = '0;
  logic        host_strobe = 1'b0;
  logic        frame_start = 1'b0;
  logic        err_clear = 1'b0;
  logic [15:0] idle_limit = 16'd30;
  logic [NCH*5-1:0]  sat_num;
  logic [NCH*7-1:0]  amplitude;
  logic [NCH*2-1:0]  roll_flags;
  logic [NCH*18-1:0] phase;
  logic        params_valid;
  logic        frame_error;

  int checks = 0;
  int fails = 0;
  int valid_cycles = 0;
  int valid_pulses = 0;
  logic valid_prev = 1'b0;
  logic [31:0] cur [NCH];

  always #(CLK_PERIOD/2) clk = ~clk;

  chan_frame_rx u_chan_frame_rx (
    .clk(clk), .rst_n(rst_n), .host_data(host_data), .host_strobe(host_strobe),
    .frame_start(frame_start), .err_clear(err_clear), .idle_limit(idle_limit),
    .sat_num(sat_num), .amplitude(amplitude), .roll_flags(roll_flags), .phase(phase),
    .params_valid(params_valid), .frame_error(frame_error)
  );

  always @(posedge clk) begin
    if (rst_n) begin
      if (params_valid) valid_cycles++;
      if (params_valid && !valid_prev) valid_pulses++;
      valid_prev <= params_valid;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, input int hold);
    @(negedge clk);
    host_data = b;
    host_strobe = 1'b1;
    repeat (hold) @(negedge clk);
    host_strobe = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic send_words(input logic [31:0] w [NCH], input int first, input int count, input int hold);
    for (int i = first; i < first + count; i++) begin
      logic [31:0] w1 = w[i / 4];
      send_byte(w1[31 - 8*(i % 4) -: 8], hold);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk);
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
  endtask

  task automatic check_active(input string req, input logic [31:0] w [NCH]);
    for (int k = 0; k < NCH; k++) begin
      chk(req, {sat_num[k*5 +: 5], amplitude[k*7 +: 7], roll_flags[k*2 +: 2], phase[k*18 +: 18]}, w[k]);
    end
  endtask

  function automatic logic [31:0] pack(input int s, input int a, input int f, input int p);
    return {5'(s), 7'(a), 2'(f), 18'(p)};
  endfunction

  task automatic t_reset();
    chk("R10 sat", 64'(sat_num), 0);
    chk("R10 phase", 64'(phase), 0);
    chk("R10 amp/flags", 64'({amplitude, roll_flags}), 0);
    chk("R10 valid", 64'(params_valid), 0);
    chk("R10 error", 64'(frame_error), 0);
  endtask

  task automatic t_full_frame();
    logic [31:0] w [NCH];
    int p0 = valid_pulses;
    w[0] = pack(1, 7'h40, 1, 18'h2_0001);
    w[1] = pack(17, 7'h03, 2, 18'h1_2345);
    w[2] = pack(30, 7'h7f, 3, 18'h0_00ff);
    w[3] = pack(9, 7'h15, 0, 18'h3_ffff);
    send_words(w, 0, 16, 4);
    check_active("R2 R3 full frame", w);
    chk("R5 one pulse", 64'(valid_pulses - p0), 1);
    chk("R5 pulse width", 64'(valid_cycles), 64'(valid_pulses));
    cur = w;
  endtask

  task automatic t_long_strobe();
    logic [31:0] w [NCH];
    int p0 = valid_pulses;
    for (int k = 0; k < NCH; k++) w[k] = pack(20 + k, 7'h11 * (k + 1), k, 18'h1_0f00 + k);
    send_words(w, 0, 16, 25);
    check_active("R1 held strobe once", w);
    chk("R1 one pulse", 64'(valid_pulses - p0), 1);
    cur = w;
  endtask

  task automatic t_hold_midframe();
    logic [31:0] w [NCH];
    int p0 = valid_pulses;
    for (int k = 0; k < NCH; k++) w[k] = pack(3 + k, 7'h22 + k, 3 - k, 18'h0_5a5a + k);
    send_words(w, 0, 15, 4);
    check_active("R4 no change mid-frame", cur);
    chk("R4 no pulse mid-frame", 64'(valid_pulses - p0), 0);
    send_words(w, 15, 1, 4);
    check_active("R4 commit after byte 16", w);
    cur = w;
  endtask

  task automatic t_start_resync();
    logic [31:0] w [NCH];
    int p0 = valid_pulses;
    for (int k = 0; k < NCH; k++) w[k] = pack(11 + k, 7'h60 - k, k, 18'h2_a000 + k);
    send_words(w, 0, 6, 4);
    pulse_start();
    @(negedge clk);
    chk("R8 error on resync", 64'(frame_error), 1);
    check_active("R8 partial discarded", cur);
    chk("R8 no pulse", 64'(valid_pulses - p0), 0);
    send_words(w, 0, 16, 4);
    check_active("R6 realigned frame", w);
    cur = w;
  endtask

  task automatic t_err_clear();
    @(negedge clk);
    err_clear = 1'b1;
    @(negedge clk);
    err_clear = 1'b0;
    chk("R9 clear", 64'(frame_error), 0);
    pulse_start();
    @(negedge clk);
    chk("R6 start at byte 0 no error", 64'(frame_error), 0);
    send_byte(8'h55, 4);
    @(negedge clk);
    frame_start = 1'b1;
    err_clear = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    err_clear = 1'b0;
    chk("R9 set wins over clear", 64'(frame_error), 1);
    @(negedge clk);
    err_clear = 1'b1;
    @(negedge clk);
    err_clear = 1'b0;
  endtask

  task automatic t_idle();
    logic [31:0] w [NCH];
    logic [31:0] v [NCH];
    for (int k = 0; k < NCH; k++) w[k] = pack(25 - k, 7'h0c + k, 2, 18'h3_0303 + k);
    idle_limit = 16'd30;
    send_words(w, 0, 5, 4);
    repeat (60) @(negedge clk);
    chk("R7 timeout error", 64'(frame_error), 1);
    check_active("R7 partial discarded", cur);
    send_words(w, 0, 16, 4);
    check_active("R7 realigned after timeout", w);
    cur = w;
    @(negedge clk);
    err_clear = 1'b1;
    @(negedge clk);
    err_clear = 1'b0;
    for (int k = 0; k < NCH; k++) v[k] = pack(k, 7'h70 + k, 1, 18'h0_1111 * (k + 1));
    idle_limit = 16'd0;
    send_words(v, 0, 3, 4);
    repeat (60) @(negedge clk);
    send_words(v, 3, 13, 4);
    chk("R7 limit 0 disables", 64'(frame_error), 0);
    check_active("R7 limit 0 frame intact", v);
    cur = v;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_full_frame();
    t_long_strobe();
    t_hold_midframe();
    t_start_resync();
    t_err_clear();
    t_idle();
    chk("R5 pulse width overall", 64'(valid_cycles), 64'(valid_pulses));
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule